// File: doc/BRIEF.md
# Receive Completion Ring Manager

This block is the hardware half of a receive buffer queue. It keeps two circular rings in system memory. One holds free-buffer descriptors that software hands over. The other holds completion entries that the block fills in. Software sets each ring with a base address and a size in bytes, turns the engine on, and hands back entries by writing counts to two enqueue inputs. The descriptor ring and the status ring are credited separately.

Each time the receive path reports a finished frame, the block takes the next free descriptor and reads the buffer index from it. It then writes a two-word completion entry that carries that index, the frame length and the error flags. Both ring pointers step forward, wrapping at the end of the ring, and a receive event pulse follows. The flag in bit 31 of each status word tells software that it now owns the entry. Word 1 is written before word 0, so software never finds word 0 flagged while word 1 is still stale. Memory access uses a simple request/grant port. Moving the frame data is done elsewhere.

Top module: `rxq_ring_mgr`

## Requirements
- R1: After reset, `rx_active`, `frm_ready`, `mem_req` and `rx_event` are low. `rx_active` rises one clock after `rx_enable` is sampled high. While the engine is off, no memory request is made and no frame is accepted.
- R2: For each accepted frame, the block reads word 1 of the current descriptor at descriptor pointer + 4 (`mem_we` = 0). It takes the buffer index from bits 30:16 of the returned data.
- R3: The first write goes to status pointer + 4. Its data is bit 31 = 1, bits 30:16 = the buffer index and bits 15:0 = the frame length.
- R4: The second write goes to the status pointer itself. Bit 31 = 1. Bit 30 = no error, set when `frm_err[3:0]` is zero and no overrun is pending. Bits 29 and 28 = 1. Bit 20 = overrun. Bit 19 = `frm_err[3]` (framing). Bit 18 = `frm_err[2]` (runt). Bit 17 = `frm_err[1]` (extra data). Bit 16 = `frm_err[0]` (CRC error). Bit 15 = `frm_err[4]` (CRC included). All other bits are 0.
- R5: After each completed entry, both pointers advance by 8 bytes. A pointer that would reach base + length is set back to base.
- R6: An enqueue pulse adds its count to that ring's free count. The descriptor and status enqueues may arrive in the same cycle, also while a frame is being handled.
- R7: If the free descriptor count or the free status count is zero, an offered frame is dropped. It makes no memory access and consumes no entry. An overrun is recorded and appears in bit 20 (with bit 30 cleared) of the next entry written; after that entry the overrun is cleared.
- R8: `rx_event` is high for exactly one cycle, the cycle after the status word 0 write is granted.
- R9: While `mem_req` is high and `mem_gnt` is low, `mem_we`, `mem_addr` and `mem_wdata` stay unchanged.
- R10: Dropping `rx_enable` returns both pointers to their bases, clears both free counts and clears any pending overrun.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rx_enable | input | 1 | Engine on |
| desc_base | input | 32 | Descriptor ring base (8-byte aligned) |
| desc_len | input | 16 | Descriptor ring size in bytes |
| stat_base | input | 32 | Status ring base (8-byte aligned) |
| stat_len | input | 16 | Status ring size in bytes |
| desc_enq_valid | input | 1 | Descriptor credit pulse |
| desc_enq_cnt | input | 8 | Descriptors handed back |
| stat_enq_valid | input | 1 | Status credit pulse |
| stat_enq_cnt | input | 8 | Status entries handed back |
| frm_valid | input | 1 | Frame finished |
| frm_len | input | 16 | Frame length in bytes |
| frm_err | input | 5 | {crc incl, framing, runt, extra, crc err} |
| frm_ready | output | 1 | Block can take a frame report |
| mem_req | output | 1 | Memory request |
| mem_we | output | 1 | Write when high |
| mem_addr | output | 32 | Byte address |
| mem_wdata | output | 32 | Write data |
| mem_gnt | input | 1 | Request granted this cycle |
| mem_rdata | input | 32 | Read data, valid with the grant |
| rx_active | output | 1 | Receive engine active |
| rx_event | output | 1 | One-cycle completion pulse |

## Verification
The bench uses an 8-entry ring so that the pointers wrap many times. Frames have random lengths and random error flags, and grants arrive after random delays. Each entry is compared with the bit layout computed in the bench, which separates flag placement from index and length packing. Directed cases include offering frames with no descriptors, then with no status entries, and then with both credited in the same cycle. These show that a drop depends on both counts, and that the overrun appears only on the next entry. A disable/re-enable pass checks that the pointers return to base.

// File: rtl/rxq_pkg.sv
package rxq_pkg;
  localparam int WORD_BYTES  = 4;
  localparam int ENTRY_BYTES = 8;
  localparam int IDX_W       = 15;
  localparam int LEN_W       = 16;
  localparam int ERR_W       = 5;

  // status word 0 bit positions
  localparam int B_OWN   = 31;
  localparam int B_OK    = 30;
  localparam int B_EOF   = 29;
  localparam int B_EOB   = 28;
  localparam int B_OVR   = 20;
  localparam int B_FRAME = 19;
  localparam int B_RUNT  = 18;
  localparam int B_EXTRA = 17;
  localparam int B_CRC   = 16;
  localparam int B_CRCIN = 15;

  // frm_err input positions
  localparam int E_CRC   = 0;
  localparam int E_EXTRA = 1;
  localparam int E_RUNT  = 2;
  localparam int E_FRAME = 3;
  localparam int E_CRCIN = 4;

  typedef enum logic [1:0] {S_IDLE, S_RD_DESC, S_WR_ST1, S_WR_ST0} seq_state_e;

  function automatic logic [31:0] stat0_word(input logic [ERR_W-1:0] err, input logic ovr);
    logic [31:0] w;
    w          = '0;
    w[B_OWN]   = 1'b1;
    w[B_OK]    = ~(|err[E_FRAME:E_CRC]) & ~ovr;
    w[B_EOF]   = 1'b1;
    w[B_EOB]   = 1'b1;
    w[B_OVR]   = ovr;
    w[B_FRAME] = err[E_FRAME];
    w[B_RUNT]  = err[E_RUNT];
    w[B_EXTRA] = err[E_EXTRA];
    w[B_CRC]   = err[E_CRC];
    w[B_CRCIN] = err[E_CRCIN];
    return w;
  endfunction
endpackage

// File: rtl/rxq_rst_sync.sv
module rxq_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);
  logic [1:0] stage_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stage_q <= 2'b00;
    else        stage_q <= {stage_q[0], 1'b1};
  end

  assign rst_n_sync = stage_q[1];
endmodule

// File: rtl/rxq_ring_ptr.sv
module rxq_ring_ptr #(
  parameter int AW = 32,
  parameter int LW = 16,
  parameter int CW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          en,
  input  logic [AW-1:0] base,
  input  logic [LW-1:0] len,
  input  logic          enq_valid,
  input  logic [CW-1:0] enq_cnt,
  input  logic          consume,
  output logic [AW-1:0] ptr,
  output logic          has_room
);
  import rxq_pkg::*;

  localparam logic [AW:0] STEP = (AW+1)'(ENTRY_BYTES);

  logic [AW-1:0] ptr_q, ptr_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic [AW:0]   ptr_next_wide, ring_end;
  logic          upd;

  assign ptr_next_wide = {1'b0, ptr_q} + STEP;
  assign ring_end      = {1'b0, base} + (AW+1)'(len);

  always_comb begin
    ptr_d = ptr_q;
    cnt_d = cnt_q;
    upd   = 1'b0;
    if (!en) begin
      ptr_d = base;
      cnt_d = '0;
      upd   = 1'b1;
    end else begin
      if (consume) begin
        ptr_d = (ptr_next_wide >= ring_end) ? base : ptr_next_wide[AW-1:0];
        upd   = 1'b1;
      end
      if (enq_valid || consume) begin
        cnt_d = cnt_q + (enq_valid ? enq_cnt : '0) - (consume ? CW'(1) : '0);
        upd   = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ptr_q <= '0;
      cnt_q <= '0;
    end else if (upd) begin
      ptr_q <= ptr_d;
      cnt_q <= cnt_d;
    end
  end

  assign ptr      = ptr_q;
  assign has_room = (cnt_q != '0);

  // R7: an entry is never taken from an empty ring
  a_r7_no_underflow: assert property (@(posedge clk) disable iff (!rst_n)
    (en && consume) |-> has_room);

  // R5: pointer stays inside the ring while running
  a_r5_ptr_in_ring: assert property (@(posedge clk) disable iff (!rst_n)
    (en && $past(en) && $stable(base) && $stable(len) && len != '0)
      |-> ({1'b0, ptr} >= {1'b0, base} && {1'b0, ptr} < ring_end));

  // R10: disabling returns the pointer to base
  a_r10_rewind: assert property (@(posedge clk) disable iff (!rst_n)
    (!en && $stable(base)) |=> (ptr == base && !has_room));
endmodule

// File: rtl/rxq_seq.sv
module rxq_seq #(
  parameter int AW = 32
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      en,
  input  logic                      frm_valid,
  input  logic [rxq_pkg::LEN_W-1:0] frm_len,
  input  logic [rxq_pkg::ERR_W-1:0] frm_err,
  output logic                      frm_ready,
  input  logic                      room,
  input  logic [AW-1:0]             dptr,
  input  logic [AW-1:0]             sptr,
  output logic                      consume,
  output logic                      mem_req,
  output logic                      mem_we,
  output logic [AW-1:0]             mem_addr,
  output logic [31:0]               mem_wdata,
  input  logic                      mem_gnt,
  input  logic [31:0]               mem_rdata,
  output logic                      rx_event
);
  import rxq_pkg::*;

  localparam logic [AW-1:0] W1_OFS = AW'(WORD_BYTES);

  seq_state_e       state_q, state_d;
  logic [LEN_W-1:0] len_q, len_d;
  logic [ERR_W-1:0] err_q, err_d;
  logic [IDX_W-1:0] idx_q, idx_d;
  logic             ovr_q, ovr_d;
  logic             evt_q, evt_d;
  logic             cap_frame, cap_idx;

  always_comb begin
    state_d   = state_q;
    ovr_d     = ovr_q;
    evt_d     = 1'b0;
    cap_frame = 1'b0;
    cap_idx   = 1'b0;
    consume   = 1'b0;
    mem_req   = 1'b0;
    mem_we    = 1'b0;
    mem_addr  = '0;
    mem_wdata = '0;
    frm_ready = en && (state_q == S_IDLE);
    if (!en) begin
      state_d = S_IDLE;
      ovr_d   = 1'b0;
    end else begin
      unique case (state_q)
        S_IDLE: begin
          if (frm_valid) begin
            if (room) begin
              cap_frame = 1'b1;
              state_d   = S_RD_DESC;
            end else begin
              ovr_d = 1'b1;
            end
          end
        end
        S_RD_DESC: begin
          mem_req  = 1'b1;
          mem_addr = dptr + W1_OFS;
          if (mem_gnt) begin
            cap_idx = 1'b1;
            state_d = S_WR_ST1;
          end
        end
        S_WR_ST1: begin
          mem_req   = 1'b1;
          mem_we    = 1'b1;
          mem_addr  = sptr + W1_OFS;
          mem_wdata = {1'b1, idx_q, len_q};
          if (mem_gnt) state_d = S_WR_ST0;
        end
        S_WR_ST0: begin
          mem_req   = 1'b1;
          mem_we    = 1'b1;
          mem_addr  = sptr;
          mem_wdata = stat0_word(err_q, ovr_q);
          if (mem_gnt) begin
            consume = 1'b1;
            evt_d   = 1'b1;
            ovr_d   = 1'b0;
            state_d = S_IDLE;
          end
        end
        default: state_d = S_IDLE;
      endcase
    end
  end

  always_comb begin
    len_d = cap_frame ? frm_len : len_q;
    err_d = cap_frame ? frm_err : err_q;
    idx_d = cap_idx ? mem_rdata[30:16] : idx_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= S_IDLE;
      ovr_q   <= 1'b0;
      evt_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      ovr_q   <= ovr_d;
      evt_q   <= evt_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      len_q <= '0;
      err_q <= '0;
    end else if (cap_frame) begin
      len_q <= len_d;
      err_q <= err_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       idx_q <= '0;
    else if (cap_idx) idx_q <= idx_d;
  end

  assign rx_event = evt_q;

  // R9: request fields hold until granted
  a_r9_hold_request: assert property (@(posedge clk) disable iff (!rst_n || !en)
    (mem_req && !mem_gnt) |=> (mem_req && $stable(mem_addr) && $stable(mem_we) && $stable(mem_wdata)));

  // R8: event follows a granted word-0 write at the status pointer
  a_r8_event_after_w0: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rx_event) |-> $past(mem_req && mem_we && mem_gnt && mem_addr == sptr));

  // R7: a frame offered without room makes no memory access
  a_r7_drop_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (en && frm_valid && frm_ready && !room) |=> !mem_req);

  // R1: nothing happens while the engine is off
  a_r1_off_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !en |-> (!mem_req && !frm_ready));
endmodule

// File: rtl/rxq_ring_mgr.sv
module rxq_ring_mgr #(
  parameter int AW = 32,
  parameter int LW = 16,
  parameter int CW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          rx_enable,
  input  logic [AW-1:0] desc_base,
  input  logic [LW-1:0] desc_len,
  input  logic [AW-1:0] stat_base,
  input  logic [LW-1:0] stat_len,
  input  logic          desc_enq_valid,
  input  logic [CW-1:0] desc_enq_cnt,
  input  logic          stat_enq_valid,
  input  logic [CW-1:0] stat_enq_cnt,
  input  logic          frm_valid,
  input  logic [15:0]   frm_len,
  input  logic [4:0]    frm_err,
  output logic          frm_ready,
  output logic          mem_req,
  output logic          mem_we,
  output logic [AW-1:0] mem_addr,
  output logic [31:0]   mem_wdata,
  input  logic          mem_gnt,
  input  logic [31:0]   mem_rdata,
  output logic          rx_active,
  output logic          rx_event
);
  logic          rst_n_s;
  logic          active_q;
  logic          consume;
  logic [AW-1:0] dptr, sptr;
  logic          d_room, s_room;

  rxq_rst_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_n_sync (rst_n_s)
  );

  always_ff @(posedge clk or negedge rst_n_s) begin
    if (!rst_n_s) active_q <= 1'b0;
    else          active_q <= rx_enable;
  end

  assign rx_active = active_q;

  rxq_ring_ptr #(.AW(AW), .LW(LW), .CW(CW)) u_desc_ring (
    .clk       (clk),
    .rst_n     (rst_n_s),
    .en        (rx_enable),
    .base      (desc_base),
    .len       (desc_len),
    .enq_valid (desc_enq_valid),
    .enq_cnt   (desc_enq_cnt),
    .consume   (consume),
    .ptr       (dptr),
    .has_room  (d_room)
  );

  rxq_ring_ptr #(.AW(AW), .LW(LW), .CW(CW)) u_stat_ring (
    .clk       (clk),
    .rst_n     (rst_n_s),
    .en        (rx_enable),
    .base      (stat_base),
    .len       (stat_len),
    .enq_valid (stat_enq_valid),
    .enq_cnt   (stat_enq_cnt),
    .consume   (consume),
    .ptr       (sptr),
    .has_room  (s_room)
  );

  rxq_seq #(.AW(AW)) u_seq (
    .clk       (clk),
    .rst_n     (rst_n_s),
    .en        (active_q && rx_enable),
    .frm_valid (frm_valid),
    .frm_len   (frm_len),
    .frm_err   (frm_err),
    .frm_ready (frm_ready),
    .room      (d_room && s_room),
    .dptr      (dptr),
    .sptr      (sptr),
    .consume   (consume),
    .mem_req   (mem_req),
    .mem_we    (mem_we),
    .mem_addr  (mem_addr),
    .mem_wdata (mem_wdata),
    .mem_gnt   (mem_gnt),
    .mem_rdata (mem_rdata),
    .rx_event  (rx_event)
  );

  // R1: active follows enable by one clock
  a_r1_active_follows: assert property (@(posedge clk) disable iff (!rst_n_s)
    $rose(rx_enable) |=> rx_active);
endmodule

// File: tb/tb_rxq_ring_mgr.sv
module tb_rxq_ring_mgr;
  localparam logic [31:0] DBASE = 32'h0000_1000;
  localparam logic [31:0] SBASE = 32'h0000_2000;
  localparam int          NENT  = 8;
  localparam logic [15:0] RLEN  = 16'(NENT * 8);

  logic clk = 1'b0;
  logic rst_n;
  logic rx_enable;
  logic desc_enq_valid, stat_enq_valid;
  logic [7:0] desc_enq_cnt, stat_enq_cnt;
  logic frm_valid;
  logic [15:0] frm_len;
  logic [4:0] frm_err;
  logic frm_ready, mem_req, mem_we, mem_gnt, rx_active, rx_event;
  logic [31:0] mem_addr, mem_wdata, mem_rdata;

  int n_chk = 0, n_fail = 0;
  int wcount, rcount;
  logic [31:0] wlog_addr [2];
  logic [31:0] wlog_data [2];
  logic [31:0] rd_addr;
  bit evt_seen;
  bit w0_prev;
  bit hold;
  logic [31:0] hold_addr, hold_data;
  logic hold_we;

  logic [31:0] exp_dptr, exp_sptr;
  int exp_dcnt, exp_scnt;
  bit exp_ovr;

  always #4 clk = ~clk;

  rxq_ring_mgr dut (
    .clk(clk), .rst_n(rst_n), .rx_enable(rx_enable),
    .desc_base(DBASE), .desc_len(RLEN), .stat_base(SBASE), .stat_len(RLEN),
    .desc_enq_valid(desc_enq_valid), .desc_enq_cnt(desc_enq_cnt),
    .stat_enq_valid(stat_enq_valid), .stat_enq_cnt(stat_enq_cnt),
    .frm_valid(frm_valid), .frm_len(frm_len), .frm_err(frm_err), .frm_ready(frm_ready),
    .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_gnt(mem_gnt), .mem_rdata(mem_rdata), .rx_active(rx_active), .rx_event(rx_event)
  );

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%08h expected=%08h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] desc_w1(input logic [31:0] a);
    logic [14:0] idx;
    idx = 15'((a >> 3) ^ 32'h2a5);
    return {1'b0, idx, 16'd2048};
  endfunction

  function automatic logic [31:0] exp_w0(input logic [4:0] e, input bit ovr);
    logic [31:0] w;
    w = 32'h3000_0000;
    w[31] = 1'b1;
    w[30] = (e[3:0] == 4'd0) && !ovr;
    w[20] = ovr;
    w[19] = e[3]; w[18] = e[2]; w[17] = e[1]; w[16] = e[0]; w[15] = e[4];
    return w;
  endfunction

  function automatic logic [31:0] step(input logic [31:0] p, input logic [31:0] b);
    return (p + 32'd8 >= b + 32'(RLEN)) ? b : p + 32'd8;
  endfunction

  // memory responder with random grant delay
  initial begin
    mem_gnt = 1'b0; mem_rdata = '0; hold = 0; w0_prev = 0;
    forever begin
      @(negedge clk);
      if (rx_event) begin
        check(w0_prev, "R8 event timing", 32'd1, 32'(w0_prev));
        evt_seen = 1;
      end
      w0_prev = 0;
      if (mem_gnt) begin
        mem_gnt = 1'b0;
        hold = 0;
      end else if (mem_req) begin
        if (hold)
          check(mem_addr == hold_addr && mem_we == hold_we && mem_wdata == hold_data,
                "R9 hold", mem_addr, hold_addr);
        if ($urandom % 3 != 0) begin
          mem_gnt = 1'b1;
          hold = 0;
          if (mem_we) begin
            if (wcount < 2) begin
              wlog_addr[wcount] = mem_addr;
              wlog_data[wcount] = mem_wdata;
            end
            wcount++;
            if (mem_addr[2] == 1'b0) w0_prev = 1;
          end else begin
            rd_addr = mem_addr;
            rcount++;
            mem_rdata = desc_w1(mem_addr);
          end
        end else begin
          hold = 1; hold_addr = mem_addr; hold_we = mem_we; hold_data = mem_wdata;
        end
      end else begin
        hold = 0;
      end
    end
  end

  task automatic enqueue(input int d, input int s);
    @(negedge clk);
    desc_enq_valid = (d != 0); desc_enq_cnt = 8'(d);
    stat_enq_valid = (s != 0); stat_enq_cnt = 8'(s);
    @(negedge clk);
    desc_enq_valid = 0; stat_enq_valid = 0;
    exp_dcnt += d; exp_scnt += s;
  endtask

  task automatic do_frame(input logic [15:0] len, input logic [4:0] err);
    bit drop;
    logic [14:0] idx;
    drop = (exp_dcnt == 0 || exp_scnt == 0);
    @(negedge clk);
    while (!frm_ready) @(negedge clk);
    wcount = 0; rcount = 0; evt_seen = 0;
    frm_valid = 1; frm_len = len; frm_err = err;
    @(negedge clk);
    frm_valid = 0;
    if (drop) begin
      repeat (6) @(negedge clk);
      check(wcount == 0 && rcount == 0, "R7 drop without access", 32'(wcount + rcount), 32'd0);
      exp_ovr = 1;
    end else begin
      for (int t = 0; t < 60 && !evt_seen; t++) @(negedge clk);
      check(evt_seen, "R8 event seen", 32'(evt_seen), 32'd1);
      check(rcount == 1 && rd_addr == exp_dptr + 4, "R2 desc read addr", rd_addr, exp_dptr + 4);
      idx = desc_w1(exp_dptr + 4)[30:16];
      check(wcount == 2, "R3 two writes", 32'(wcount), 32'd2);
      check(wlog_addr[0] == exp_sptr + 4 && wlog_data[0] == {1'b1, idx, len},
            "R3 word1", wlog_data[0], {1'b1, idx, len});
      check(wlog_addr[1] == exp_sptr && wlog_data[1] == exp_w0(err, exp_ovr),
            "R4 word0", wlog_data[1], exp_w0(err, exp_ovr));
      exp_dptr = step(exp_dptr, DBASE);
      exp_sptr = step(exp_sptr, SBASE);
      exp_dcnt--; exp_scnt--;
      exp_ovr = 0;
    end
  endtask

  task automatic finish_run();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog actual=%08h expected=%08h", 32'd0, 32'd1);
    finish_run();
  end

  initial begin
    void'($urandom(32'd1234));
    rst_n = 0; rx_enable = 0; frm_valid = 0; frm_len = '0; frm_err = '0;
    desc_enq_valid = 0; stat_enq_valid = 0; desc_enq_cnt = '0; stat_enq_cnt = '0;
    exp_dptr = DBASE; exp_sptr = SBASE; exp_dcnt = 0; exp_scnt = 0; exp_ovr = 0;
    wcount = 0; rcount = 0; evt_seen = 0;
    repeat (3) @(negedge clk);
    check(!rx_active, "R1 reset active", 32'(rx_active), 32'd0);
    check(!frm_ready, "R1 reset ready", 32'(frm_ready), 32'd0);
    check(!mem_req, "R1 reset req", 32'(mem_req), 32'd0);
    check(!rx_event, "R1 reset event", 32'(rx_event), 32'd0);
    rst_n = 1;
    repeat (4) @(negedge clk);
    check(!rx_active, "R1 off after reset", 32'(rx_active), 32'd0);
    rx_enable = 1;
    @(negedge clk);
    check(rx_active, "R1 active one clock after enable", 32'(rx_active), 32'd1);

    do_frame(16'd60, 5'd0);            // R7 both rings empty
    enqueue(3, 0);
    do_frame(16'd61, 5'd0);            // R7 status ring empty
    enqueue(0, 5);
    do_frame(16'd100, 5'd0);           // R7 overrun on next entry
    do_frame(16'd1500, 5'd0);          // R4 clean entry
    do_frame(16'd2044, 5'b11111);      // R4 all flags
    do_frame(16'd64, 5'd0);            // R7 descriptor ring empty
    enqueue(5, 6);                     // R6 both credited in one cycle

    for (int i = 0; i < 60; i++) begin // R5 wrap under random traffic
      if ($urandom % 3 == 0) begin
        int d, s;
        d = int'($urandom % 4); s = int'($urandom % 4);
        if (exp_dcnt + d > NENT) d = NENT - exp_dcnt;
        if (exp_scnt + s > NENT) s = NENT - exp_scnt;
        enqueue(d, s);
      end
      do_frame(16'(64 + $urandom % 1981), ($urandom % 2 == 0) ? 5'd0 : 5'($urandom));
    end

    // R10 disable rewinds pointers and clears counts and overrun
    do_frame(16'd70, 5'd0);
    if (exp_dcnt == 0 || exp_scnt == 0) begin end
    @(negedge clk);
    rx_enable = 0;
    repeat (2) @(negedge clk);
    check(!rx_active && !frm_ready, "R10 off", 32'(rx_active), 32'd0);
    rx_enable = 1;
    exp_dptr = DBASE; exp_sptr = SBASE; exp_dcnt = 0; exp_scnt = 0; exp_ovr = 0;
    repeat (2) @(negedge clk);
    enqueue(2, 2);
    do_frame(16'd200, 5'd0);           // R10 entry at ring bases, no overrun
    do_frame(16'd300, 5'b00001);
    do_frame(16'd400, 5'd0);           // R7 after counts used up
    repeat (4) @(negedge clk);
    finish_run();
  end
endmodule